// File: doc/BRIEF.md
# Power Controller Request Bridge

This block links a host register port to a power-management microcontroller. The host sends two kinds of work through it. The first is a performance-level change for one of two CPU clusters. The second is a generic configuration read or write. A configuration transaction is built from a command word plus a separate outgoing-data register. The result of a configuration read comes back in a separate incoming-data register.

Every request travels over a single req/ack channel to the microcontroller, so only one is ever in flight. Each request kind owns a 4-bit nibble in the status word, and that nibble records completion or failure. A level-high interrupt tells the host that a response has landed. Reading the status word consumes all the flags at once.

The host port is a plain one-cycle valid/write/address/data bus with combinational read data. The word addresses are: 0 command, 1 outgoing data, 2 incoming data, 3 level of cluster 0, 4 level of cluster 1, 5 status. Other addresses read as zero and ignore writes.

Top module: `pmc_req_bridge`

## Requirements
- R1: After reset, the microcontroller request (`mcu_req`) is low and `irq` is low. The status word reads 0x3000_0000. Both level registers read 0 and the command register reads 0.
- R2: A host write to address 0 with bit 31 set launches a request of kind 2. Its fields are: write flag = bit 30, function = bits 25:20, device = bits 11:0, data = the current address-1 register. A write to address 0 with bit 31 clear launches nothing.
- R3: A host write to address 3 or 4 launches a request of kind 0 or 1. It has write flag 1 and data = host bits 2:0 (level 0..7). While that request is open, reading the level register returns the old level. After an ack without error it returns the new level.
- R4: `mcu_req` rises in the cycle after the launching host write. Kind, write flag, function, device and data stay stable while `mcu_req` is high. `mcu_req` falls in the cycle after `mcu_ack` is sampled high.
- R5: An ack without error sets status bit 4*kind. An ack with `mcu_err` sets bit 4*kind+1 instead. Address 2 captures `mcu_rdata` only on an error-free ack of a kind-2 read.
- R6: `irq` is high exactly while any completion or error flag is set. It first rises in the cycle after the ack edge.
- R7: A status read returns the word as it stood, then clears every flag including the busy-error bit. `irq` is low from the next cycle. An ack that lands in the same cycle as the read is not lost.
- R8: While a request is open, further command-start or level writes are dropped. They leave the open request and the command readback untouched, and set sticky status bit 16, which does not drive `irq`.
- R9: Command readback bit 31 is 1 while a kind-2 request is open and 0 otherwise. Bits 30, 25:20 and 11:0 echo the last launched configuration command.
- R10: Status bits 29:28 give the kind of the open request, or 3 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_vld | input | 1 | Host access valid this cycle |
| hst_wr | input | 1 | Host access is a write |
| hst_addr | input | ADDR_W | Host word address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data (combinational) |
| irq | output | 1 | Level-high response interrupt |
| mcu_req | output | 1 | Request to microcontroller |
| mcu_type | output | 2 | Request kind: 0/1 cluster level, 2 configuration |
| mcu_wr | output | 1 | Request is a write |
| mcu_func | output | 6 | Configuration function code |
| mcu_dev | output | 12 | Configuration device/address |
| mcu_wdata | output | 32 | Request data |
| mcu_ack | input | 1 | Microcontroller response strobe |
| mcu_err | input | 1 | Response carries an error, valid with ack |
| mcu_rdata | input | 32 | Response data, valid with ack |

## Verification
The hardest case to reach from the ports is the status read that coincides with an incoming ack. Only one host access fits in a cycle, so the collision cannot come from the bus alone. The bench drives the ack strobe and the status read on the same falling edge. It then checks two things: the read returned the pre-ack word, and the completion flag plus the interrupt survived the clear. Dropped busy writes are also forced deliberately: level and command writes are issued between launch and ack, and the open request and the command readback are observed at the ports.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int DATA_W      = 32;
  localparam int FUNC_W      = 6;
  localparam int DEV_W       = 12;
  localparam int LVL_W       = 3;
  localparam int NCLUST      = 2;
  localparam int NTYPES      = 3;
  localparam int START_BIT   = 31;
  localparam int WRF_BIT     = 30;
  localparam int FUNC_LSB    = 20;
  localparam int BUSYERR_BIT = 16;
  localparam int PEND_LSB    = 28;

  localparam int RA_CMD   = 0;
  localparam int RA_WDATA = 1;
  localparam int RA_RDATA = 2;
  localparam int RA_PERF0 = 3;
  localparam int RA_STAT  = RA_PERF0 + NCLUST;

  typedef enum logic [1:0] {
    RT_PERF0 = 2'd0,
    RT_PERF1 = 2'd1,
    RT_CFG   = 2'd2,
    RT_NONE  = 2'd3
  } rtype_e;

  typedef struct packed {
    rtype_e              kind;
    logic                wr;
    logic [FUNC_W-1:0]   func;
    logic [DEV_W-1:0]    dev;
    logic [DATA_W-1:0]   data;
  } req_t;
endpackage

// File: rtl/pmc_decode.sv
module pmc_decode
  import pmc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                    hst_vld,
  input  logic                    hst_wr,
  input  logic [ADDR_W-1:0]       hst_addr,
  input  logic [DATA_W-1:0]       hst_wdata,
  input  logic                    busy,
  input  rtype_e                  pend_kind,
  input  logic [DATA_W-1:0]       wdata_q,
  input  logic [DATA_W-1:0]       rdata_q,
  input  logic                    cmd_wr,
  input  logic [FUNC_W-1:0]       cmd_func,
  input  logic [DEV_W-1:0]        cmd_dev,
  input  logic [NCLUST*LVL_W-1:0] lvl_flat,
  input  logic [NTYPES-1:0]       cmp_flags,
  input  logic [NTYPES-1:0]       err_flags,
  input  logic                    busy_err,
  output logic                    launch,
  output req_t                    launch_req,
  output logic                    wdata_we,
  output logic                    stat_rd,
  output logic                    busy_hit,
  output logic [DATA_W-1:0]       hst_rdata
);
  logic              wr_acc;
  logic              rd_acc;
  logic              cmd_go;
  logic [NCLUST-1:0] perf_hit;
  logic              want;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] cmd_word;

  assign wr_acc   = hst_vld & hst_wr;
  assign rd_acc   = hst_vld & ~hst_wr;
  assign cmd_go   = wr_acc & (hst_addr == ADDR_W'(RA_CMD)) & hst_wdata[START_BIT];
  assign wdata_we = wr_acc & (hst_addr == ADDR_W'(RA_WDATA));
  assign stat_rd  = rd_acc & (hst_addr == ADDR_W'(RA_STAT));

  for (genvar c = 0; c < NCLUST; c++) begin : g_perf_hit
    assign perf_hit[c] = wr_acc & (hst_addr == ADDR_W'(RA_PERF0 + c));
  end

  assign want     = cmd_go | (|perf_hit);
  assign launch   = want & ~busy;
  assign busy_hit = want & busy;

  always_comb begin
    launch_req      = '0;
    launch_req.kind = RT_NONE;
    if (cmd_go) begin
      launch_req.kind = RT_CFG;
      launch_req.wr   = hst_wdata[WRF_BIT];
      launch_req.func = hst_wdata[FUNC_LSB +: FUNC_W];
      launch_req.dev  = hst_wdata[DEV_W-1:0];
      launch_req.data = wdata_q;
    end
    for (int c = 0; c < NCLUST; c++) begin
      if (perf_hit[c]) begin
        launch_req.kind = rtype_e'(2'(c));
        launch_req.wr   = 1'b1;
        launch_req.data = DATA_W'(hst_wdata[LVL_W-1:0]);
      end
    end
  end

  always_comb begin
    stat_word = '0;
    for (int t = 0; t < NTYPES; t++) begin
      stat_word[4*t]   = cmp_flags[t];
      stat_word[4*t+1] = err_flags[t];
    end
    stat_word[BUSYERR_BIT]     = busy_err;
    stat_word[PEND_LSB +: 2]   = pend_kind;
  end

  always_comb begin
    cmd_word                      = '0;
    cmd_word[START_BIT]           = busy & (pend_kind == RT_CFG);
    cmd_word[WRF_BIT]             = cmd_wr;
    cmd_word[FUNC_LSB +: FUNC_W]  = cmd_func;
    cmd_word[DEV_W-1:0]           = cmd_dev;
  end

  always_comb begin
    hst_rdata = '0;
    if (rd_acc) begin
      if (hst_addr == ADDR_W'(RA_CMD))   hst_rdata = cmd_word;
      if (hst_addr == ADDR_W'(RA_WDATA)) hst_rdata = wdata_q;
      if (hst_addr == ADDR_W'(RA_RDATA)) hst_rdata = rdata_q;
      if (hst_addr == ADDR_W'(RA_STAT))  hst_rdata = stat_word;
      for (int c = 0; c < NCLUST; c++) begin
        if (hst_addr == ADDR_W'(RA_PERF0 + c))
          hst_rdata = DATA_W'(lvl_flat[c*LVL_W +: LVL_W]);
      end
    end
  end
endmodule

// File: rtl/pmc_launch.sv
module pmc_launch
  import pmc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    launch,
  input  req_t                    launch_req,
  input  logic                    wdata_we,
  input  logic [DATA_W-1:0]       hst_wdata,
  input  logic                    mcu_ack,
  input  logic                    mcu_err,
  input  logic [DATA_W-1:0]       mcu_rdata,
  output logic                    mcu_req,
  output req_t                    req_q,
  output logic                    busy,
  output rtype_e                  pend_kind,
  output logic                    done,
  output logic [DATA_W-1:0]       wdata_q,
  output logic [DATA_W-1:0]       rdata_q,
  output logic                    cmd_wr,
  output logic [FUNC_W-1:0]       cmd_func,
  output logic [DEV_W-1:0]        cmd_dev,
  output logic [NCLUST*LVL_W-1:0] lvl_flat
);
  logic req_on;
  logic req_on_d;
  logic req_on_en;
  logic req_en;
  logic rdata_en;
  logic cmd_en;

  assign done      = req_on & mcu_ack;
  assign busy      = req_on;
  assign mcu_req   = req_on;
  assign pend_kind = req_on ? req_q.kind : RT_NONE;

  always_comb begin
    req_on_d  = req_on;
    req_on_en = 1'b0;
    if (done) begin
      req_on_d  = 1'b0;
      req_on_en = 1'b1;
    end else if (launch) begin
      req_on_d  = 1'b1;
      req_on_en = 1'b1;
    end
  end

  assign req_en   = launch & ~req_on;
  assign rdata_en = done & (req_q.kind == RT_CFG) & ~req_q.wr & ~mcu_err;
  assign cmd_en   = req_en & (launch_req.kind == RT_CFG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         req_on <= 1'b0;
    else if (req_on_en) req_on <= req_on_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q      <= '0;
      req_q.kind <= RT_NONE;
    end else if (req_en) begin
      req_q <= launch_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wdata_q <= '0;
    else if (wdata_we) wdata_q <= hst_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= mcu_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_wr   <= 1'b0;
      cmd_func <= '0;
      cmd_dev  <= '0;
    end else if (cmd_en) begin
      cmd_wr   <= launch_req.wr;
      cmd_func <= launch_req.func;
      cmd_dev  <= launch_req.dev;
    end
  end

  for (genvar c = 0; c < NCLUST; c++) begin : g_lvl
    logic             lvl_en;
    logic [LVL_W-1:0] lvl_q;
    assign lvl_en = done & (req_q.kind == rtype_e'(2'(c))) & ~mcu_err;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lvl_q <= '0;
      else if (lvl_en) lvl_q <= req_q.data[LVL_W-1:0];
    end
    assign lvl_flat[c*LVL_W +: LVL_W] = lvl_q;
  end
endmodule

// File: rtl/pmc_status.sv
module pmc_status
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  rtype_e            done_kind,
  input  logic              done_err,
  input  logic              busy_hit,
  input  logic              stat_rd,
  output logic [NTYPES-1:0] cmp_flags,
  output logic [NTYPES-1:0] err_flags,
  output logic              busy_err,
  output logic              irq
);
  for (genvar t = 0; t < NTYPES; t++) begin : g_flag
    logic set_cmp;
    logic set_err;
    logic cmp_d;
    logic err_d;
    logic cmp_en;
    logic err_en;
    assign set_cmp = done & (done_kind == rtype_e'(2'(t))) & ~done_err;
    assign set_err = done & (done_kind == rtype_e'(2'(t))) & done_err;
    assign cmp_d   = set_cmp | (cmp_flags[t] & ~stat_rd);
    assign err_d   = set_err | (err_flags[t] & ~stat_rd);
    assign cmp_en  = set_cmp | stat_rd;
    assign err_en  = set_err | stat_rd;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_flags[t] <= 1'b0;
      else if (cmp_en) cmp_flags[t] <= cmp_d;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      err_flags[t] <= 1'b0;
      else if (err_en) err_flags[t] <= err_d;
    end
  end

  logic berr_d;
  logic berr_en;
  assign berr_d  = busy_hit | (busy_err & ~stat_rd);
  assign berr_en = busy_hit | stat_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_err <= 1'b0;
    else if (berr_en) busy_err <= berr_d;
  end

  assign irq = (|cmp_flags) | (|err_flags);
endmodule

// File: rtl/pmc_req_bridge.sv
module pmc_req_bridge
  import pmc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_vld,
  input  logic              hst_wr,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [31:0]       hst_wdata,
  output logic [31:0]       hst_rdata,
  output logic              irq,
  output logic              mcu_req,
  output logic [1:0]        mcu_type,
  output logic              mcu_wr,
  output logic [5:0]        mcu_func,
  output logic [11:0]       mcu_dev,
  output logic [31:0]       mcu_wdata,
  input  logic              mcu_ack,
  input  logic              mcu_err,
  input  logic [31:0]       mcu_rdata
);
  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  logic                    launch;
  req_t                    launch_req;
  logic                    wdata_we;
  logic                    stat_rd;
  logic                    busy_hit;
  req_t                    req_q;
  logic                    busy;
  rtype_e                  pend_kind;
  logic                    done;
  logic [DATA_W-1:0]       wdata_q;
  logic [DATA_W-1:0]       rdata_q;
  logic                    cmd_wr;
  logic [FUNC_W-1:0]       cmd_func;
  logic [DEV_W-1:0]        cmd_dev;
  logic [NCLUST*LVL_W-1:0] lvl_flat;
  logic [NTYPES-1:0]       cmp_flags;
  logic [NTYPES-1:0]       err_flags;
  logic                    busy_err;

  pmc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .hst_vld(hst_vld), .hst_wr(hst_wr), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .busy(busy), .pend_kind(pend_kind), .wdata_q(wdata_q), .rdata_q(rdata_q),
    .cmd_wr(cmd_wr), .cmd_func(cmd_func), .cmd_dev(cmd_dev), .lvl_flat(lvl_flat),
    .cmp_flags(cmp_flags), .err_flags(err_flags), .busy_err(busy_err),
    .launch(launch), .launch_req(launch_req), .wdata_we(wdata_we),
    .stat_rd(stat_rd), .busy_hit(busy_hit), .hst_rdata(hst_rdata)
  );

  pmc_launch u_lch (
    .clk(clk), .rst_n(rst_core_n), .launch(launch), .launch_req(launch_req),
    .wdata_we(wdata_we), .hst_wdata(hst_wdata), .mcu_ack(mcu_ack),
    .mcu_err(mcu_err), .mcu_rdata(mcu_rdata), .mcu_req(mcu_req), .req_q(req_q),
    .busy(busy), .pend_kind(pend_kind), .done(done), .wdata_q(wdata_q),
    .rdata_q(rdata_q), .cmd_wr(cmd_wr), .cmd_func(cmd_func), .cmd_dev(cmd_dev),
    .lvl_flat(lvl_flat)
  );

  pmc_status u_sts (
    .clk(clk), .rst_n(rst_core_n), .done(done), .done_kind(req_q.kind),
    .done_err(mcu_err), .busy_hit(busy_hit), .stat_rd(stat_rd),
    .cmp_flags(cmp_flags), .err_flags(err_flags), .busy_err(busy_err), .irq(irq)
  );

  assign mcu_type  = req_q.kind;
  assign mcu_wr    = req_q.wr;
  assign mcu_func  = req_q.func;
  assign mcu_dev   = req_q.dev;
  assign mcu_wdata = req_q.data;
endmodule

// File: rtl/pmc_req_bridge_chk.sv
module pmc_req_bridge_chk
  import pmc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hst_vld,
  input logic              hst_wr,
  input logic [ADDR_W-1:0] hst_addr,
  input logic [31:0]       hst_rdata,
  input logic              irq,
  input logic              mcu_req,
  input logic [1:0]        mcu_type,
  input logic              mcu_wr,
  input logic [5:0]        mcu_func,
  input logic [11:0]       mcu_dev,
  input logic [31:0]       mcu_wdata,
  input logic              mcu_ack
);
  assert_hold_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_req && !mcu_ack) |=> (mcu_req && $stable(mcu_type) && $stable(mcu_wr)
      && $stable(mcu_func) && $stable(mcu_dev) && $stable(mcu_wdata)));

  assert_drop_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_req && mcu_ack) |=> !mcu_req);

  assert_irq_on_response_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_req && mcu_ack) |=> irq);

  assert_read_clears_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_vld && !hst_wr && hst_addr == ADDR_W'(RA_STAT) && !(mcu_req && mcu_ack))
      |=> !irq);

  assert_kind_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mcu_req |-> (mcu_type != 2'd3));

  assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_vld && !hst_wr && hst_addr == ADDR_W'(RA_CMD) && !mcu_req)
      |-> !hst_rdata[START_BIT]);
endmodule

bind pmc_req_bridge pmc_req_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_vld(hst_vld), .hst_wr(hst_wr),
  .hst_addr(hst_addr), .hst_rdata(hst_rdata), .irq(irq), .mcu_req(mcu_req),
  .mcu_type(mcu_type), .mcu_wr(mcu_wr), .mcu_func(mcu_func),
  .mcu_dev(mcu_dev), .mcu_wdata(mcu_wdata), .mcu_ack(mcu_ack)
);

// File: tb/pmc_req_bridge_test.sv
`timescale 1ns/1ps
module pmc_req_bridge_test;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hst_vld = 1'b0;
  logic          hst_wr = 1'b0;
  logic [AW-1:0] hst_addr = '0;
  logic [31:0]   hst_wdata = '0;
  logic [31:0]   hst_rdata;
  logic          irq;
  logic          mcu_req;
  logic [1:0]    mcu_type;
  logic          mcu_wr;
  logic [5:0]    mcu_func;
  logic [11:0]   mcu_dev;
  logic [31:0]   mcu_wdata;
  logic          mcu_ack = 1'b0;
  logic          mcu_err = 1'b0;
  logic [31:0]   mcu_rdata = '0;

  int vectors = 0;
  int misses = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pmc_req_bridge #(.ADDR_W(AW)) uut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      finished = 1;
      misses++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input int a, input logic [31:0] d);
    hst_vld = 1; hst_wr = 1; hst_addr = AW'(a); hst_wdata = d;
    @(negedge clk);
    hst_vld = 0; hst_wr = 0;
  endtask

  task automatic host_rd(input int a, output logic [31:0] d);
    hst_vld = 1; hst_wr = 0; hst_addr = AW'(a);
    #1 d = hst_rdata;
    @(negedge clk);
    hst_vld = 0;
  endtask

  task automatic mcu_respond(input logic e, input logic [31:0] rd);
    while (!mcu_req) @(negedge clk);
    mcu_ack = 1; mcu_err = e; mcu_rdata = rd;
    @(negedge clk);
    mcu_ack = 0; mcu_err = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 req", {31'b0, mcu_req}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    host_rd(5, v); chk("R1 status", v, 32'h3000_0000);
    host_rd(3, v); chk("R1 perf0", v, 0);
    host_rd(4, v); chk("R1 perf1", v, 0);
    host_rd(0, v); chk("R1 cmd", v, 0);
  endtask

  task automatic t_cfg_write;
    logic [31:0] v;
    host_wr(1, 32'hA5A5_1234);
    host_wr(0, 32'hC000_0000 | (32'h2A << 20) | 32'h345);
    chk("R4 req rise", {31'b0, mcu_req}, 1);
    chk("R2 type", {30'b0, mcu_type}, 2);
    chk("R2 wr", {31'b0, mcu_wr}, 1);
    chk("R2 func", {26'b0, mcu_func}, 32'h2A);
    chk("R2 dev", {20'b0, mcu_dev}, 32'h345);
    chk("R2 data", mcu_wdata, 32'hA5A5_1234);
    host_rd(0, v); chk("R9 start busy", v, 32'hC2A0_0345);
    host_rd(5, v); chk("R10 pending cfg", v, 32'h2000_0000);
    repeat (3) @(negedge clk);
    chk("R4 held req", {31'b0, mcu_req}, 1);
    chk("R4 held dev", {20'b0, mcu_dev}, 32'h345);
    mcu_respond(0, 32'h0);
    chk("R4 req drop", {31'b0, mcu_req}, 0);
    chk("R6 irq up", {31'b0, irq}, 1);
    host_rd(0, v); chk("R9 start idle", v, 32'h42A0_0345);
    host_rd(5, v); chk("R5 cfg done", v, 32'h3000_0100);
    chk("R7 irq cleared", {31'b0, irq}, 0);
    host_rd(5, v); chk("R7 status empty", v, 32'h3000_0000);
  endtask

  task automatic t_cfg_read;
    logic [31:0] v;
    host_wr(0, 32'h8000_0000 | (32'h5 << 20) | 32'h0FF);
    chk("R2 read wr", {31'b0, mcu_wr}, 0);
    mcu_respond(0, 32'hDEAD_BEEF);
    host_rd(2, v); chk("R5 rdata captured", v, 32'hDEAD_BEEF);
    host_rd(5, v); chk("R5 read done", v, 32'h3000_0100);
    host_wr(0, 32'h8000_0000 | (32'h5 << 20) | 32'h0FF);
    mcu_respond(1, 32'h1111_1111);
    chk("R6 irq on err", {31'b0, irq}, 1);
    host_rd(2, v); chk("R5 rdata kept on err", v, 32'hDEAD_BEEF);
    host_rd(5, v); chk("R5 cfg err bit", v, 32'h3000_0200);
  endtask

  task automatic t_nostart;
    host_wr(0, 32'h4000_0001);
    chk("R2 no start", {31'b0, mcu_req}, 0);
  endtask

  task automatic t_perf;
    logic [31:0] v;
    host_wr(4, 32'hFFFF_FFFD);
    chk("R3 type", {30'b0, mcu_type}, 1);
    chk("R3 wr", {31'b0, mcu_wr}, 1);
    chk("R3 data", mcu_wdata, 5);
    host_rd(4, v); chk("R3 old level", v, 0);
    mcu_respond(0, 0);
    host_rd(4, v); chk("R3 new level", v, 5);
    host_rd(3, v); chk("R3 other cluster", v, 0);
    host_rd(5, v); chk("R5 perf1 done", v, 32'h3000_0010);
    host_wr(3, 32'h6);
    mcu_respond(1, 0);
    host_rd(3, v); chk("R3 level kept on err", v, 0);
    host_rd(5, v); chk("R5 perf0 err", v, 32'h3000_0002);
  endtask

  task automatic t_busy;
    logic [31:0] v;
    host_wr(3, 32'h3);
    host_wr(0, 32'hC000_0000 | 32'h777);
    host_wr(4, 32'h7);
    chk("R8 type kept", {30'b0, mcu_type}, 0);
    chk("R8 data kept", mcu_wdata, 3);
    chk("R8 no irq", {31'b0, irq}, 0);
    host_rd(0, v); chk("R8 cmd untouched", v, 32'h0050_00FF);
    mcu_respond(0, 0);
    host_rd(4, v); chk("R8 perf1 untouched", v, 5);
    host_rd(3, v); chk("R3 perf0 set", v, 3);
    host_rd(5, v); chk("R8 busy err bit", v, 32'h3001_0001);
    host_rd(5, v); chk("R7 busy err cleared", v, 32'h3000_0000);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    host_wr(0, 32'h8010_0001);
    hst_vld = 1; hst_wr = 0; hst_addr = AW'(5);
    mcu_ack = 1; mcu_err = 0; mcu_rdata = 32'h5;
    #1 v = hst_rdata;
    @(negedge clk);
    hst_vld = 0; mcu_ack = 0;
    chk("R7 pre-ack word", v, 32'h2000_0000);
    chk("R7 irq survives", {31'b0, irq}, 1);
    host_rd(5, v); chk("R7 flag survives", v, 32'h3000_0100);
    host_rd(2, v); chk("R5 collide rdata", v, 32'h5);
  endtask

  initial begin
    #5 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_cfg_write();
    t_cfg_read();
    t_nostart();
    t_perf();
    t_busy();
    t_collide();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule